// File: doc/BRIEF.md
# Multi-Function Output-Enable Pin Controller

This block sits between three general-purpose control pins and the clock output stages of a clock generator. Each pin is given one role by a two-bit configuration field. Depending on its role, a pin can enable one output or the differential pair, act as the global power-down input, act as a power-saving input for one output, or supply one bit of a frequency-select code. The second pin can also be turned around to drive the timer's reset-out signal.

From the decoded pin functions, the register output-enable bits and the power-down state, the block computes a run or stop decision for each of the three single-ended outputs and for the differential pair. The low-frequency 32 kHz output is kept apart from power-down. Pin levels are asynchronous to the core clock, so they are resynchronized before use. Configuration, register enables and the timer request are already in the core clock domain and reach the outputs after one register stage.

Top module: `oe_pin_ctrl`

## Requirements
- R1: Output index 0, 1 and 2 are single-ended outputs 1, 2 and 3, and index 3 is the differential pair. A 0 in `reg_oe[i]` stops `out_run[i]` on the next clock edge, whatever the pins do.
- R2: Pin 1 role code 1 makes it an active-low power-down. While it is low, all four `out_run` bits are 0 and `pwrdn_active` is 1. `lf_run` follows `lf_en` regardless of power-down.
- R3: Power-saving roles are pin 1 code 2 (output 1), pin 2 code 2 (output 2) and pin 3 code 1 (output 3). A low level on such a pin stops only its own output. An output runs only when power-down is high, its register enable is 1 and its power-saving term is 1.
- R4: Enable roles are pin 1 code 0 (output 1), pin 2 code 0 (output 2), pin 2 code 1 (differential pair) and pin 3 code 0 (output 3). A low level stops only the output or outputs assigned to that pin.
- R5: A function that no pin carries takes its inactive default: power-down high, power-saving high and pin-enable high. Pin 3 code 3 gives the pin no function at all.
- R6: `fsel[0]` equals pin 1 when pin 1 has code 3 and is 0 otherwise. `fsel[1]` equals pin 3 when pin 3 has code 2 and is 0 otherwise.
- R7: Pin 2 code 3 makes pin 2 an output. `rst_pin_drive_en` is 1 and `rst_pin_level` is the inverse of `tmr_rst_req`, so reset-out is active low. The pin 2 input level has no effect on any output. With any other code, `rst_pin_drive_en` is 0 and `rst_pin_level` is 1.
- R8: A pin level change is seen on the outputs at the third rising clock edge after it is applied, and not before. A change on the configuration, `reg_oe`, `lf_en` or `tmr_rst_req` inputs is seen at the first edge.
- R9: While `rst_n` is low, all outputs are 0 except `rst_pin_level`, which is 1. Reset takes effect at once and is released in step with the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | 3 | Raw levels of pins 1..3 (bit 0 = pin 1) |
| pin1_role | input | 2 | Pin 1 role: 0 enable out1, 1 power-down, 2 save out1, 3 fsel bit 0 |
| pin2_role | input | 2 | Pin 2 role: 0 enable out2, 1 enable diff pair, 2 save out2, 3 reset-out |
| pin3_role | input | 2 | Pin 3 role: 0 enable out3, 1 save out3, 2 fsel bit 1, 3 none |
| reg_oe | input | 4 | Register output-enable per output |
| lf_en | input | 1 | 32 kHz output enable |
| tmr_rst_req | input | 1 | Reset request from the timer |
| out_run | output | 4 | Run (1) or stop (0) per output |
| pwrdn_active | output | 1 | Global power-down in effect |
| fsel | output | 2 | Frequency-select code |
| rst_pin_drive_en | output | 1 | Pin 2 output driver enable |
| rst_pin_level | output | 1 | Level driven on pin 2 when enabled |
| lf_run | output | 1 | 32 kHz output run |

## Verification
The bench targets cross-talk between pins. A low enable or power-saving pin must stop only its own output. A decoder that shared terms between outputs would stop neighbours, or leave the differential pair running while pin 2 enables it. It also checks that a pin in reset-out role cannot gate output 2, and that unassigned functions default high; a design that read stale pin levels there would stop outputs it should not touch. Power-down is checked together with the 32 kHz output, which a careless gate would also stop. The exact synchronizer latency is checked in both directions: a missing or extra stage shows up one edge early or late.

// File: rtl/oe_pin_pkg.sv
`timescale 1ns/1ps
package oe_pin_pkg;

  localparam int NUM_PINS = 3;
  localparam int NUM_OUT  = 4;
  localparam int OUT_SE1  = 0;
  localparam int OUT_SE2  = 1;
  localparam int OUT_SE3  = 2;
  localparam int OUT_DIFF = 3;

  typedef enum logic [1:0] {
    P1_SE_EN = 2'd0,
    P1_PWRDN = 2'd1,
    P1_SAVE  = 2'd2,
    P1_FSEL  = 2'd3
  } pin1_role_e;

  typedef enum logic [1:0] {
    P2_SE_EN   = 2'd0,
    P2_DIFF_EN = 2'd1,
    P2_SAVE    = 2'd2,
    P2_RSTOUT  = 2'd3
  } pin2_role_e;

  typedef enum logic [1:0] {
    P3_SE_EN = 2'd0,
    P3_SAVE  = 2'd1,
    P3_FSEL  = 2'd2,
    P3_NONE  = 2'd3
  } pin3_role_e;

  typedef struct packed {
    logic               pd_n;
    logic [NUM_OUT-1:0] pen;
    logic [NUM_OUT-1:0] save;
    logic [1:0]         fsel;
    logic               rst_oe;
    logic               rst_lvl;
  } pin_terms_t;

endpackage

// File: rtl/oe_sync.sv
`timescale 1ns/1ps
module oe_sync #(
  parameter int   WIDTH   = 1,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_comb stage_d[s] = d;
      end else begin : g_next
        always_comb stage_d[s] = stage_q[s-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= {WIDTH{RST_VAL}};
        else        stage_q[s] <= stage_d[s];
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/oe_role_decode.sv
`timescale 1ns/1ps
module oe_role_decode
  import oe_pin_pkg::*;
(
  input  logic [NUM_PINS-1:0] pin_s,
  input  pin1_role_e          role1,
  input  pin2_role_e          role2,
  input  pin3_role_e          role3,
  input  logic                rst_req,
  output pin_terms_t          terms
);

  always_comb begin
    terms         = '0;
    terms.pd_n    = 1'b1;
    terms.pen     = '1;
    terms.save    = '1;
    terms.fsel    = 2'b00;
    terms.rst_oe  = 1'b0;
    terms.rst_lvl = 1'b1;

    unique case (role1)
      P1_SE_EN: terms.pen[OUT_SE1]  = pin_s[0];
      P1_PWRDN: terms.pd_n          = pin_s[0];
      P1_SAVE:  terms.save[OUT_SE1] = pin_s[0];
      P1_FSEL:  terms.fsel[0]       = pin_s[0];
      default:  terms.pd_n          = 1'b1;
    endcase

    unique case (role2)
      P2_SE_EN:   terms.pen[OUT_SE2]  = pin_s[1];
      P2_DIFF_EN: terms.pen[OUT_DIFF] = pin_s[1];
      P2_SAVE:    terms.save[OUT_SE2] = pin_s[1];
      P2_RSTOUT: begin
        terms.rst_oe  = 1'b1;
        terms.rst_lvl = ~rst_req;
      end
      default:    terms.rst_oe = 1'b0;
    endcase

    unique case (role3)
      P3_SE_EN: terms.pen[OUT_SE3]  = pin_s[2];
      P3_SAVE:  terms.save[OUT_SE3] = pin_s[2];
      P3_FSEL:  terms.fsel[1]       = pin_s[2];
      P3_NONE:  terms.fsel[1]       = 1'b0;
      default:  terms.fsel[1]       = 1'b0;
    endcase
  end

endmodule

// File: rtl/oe_out_gate.sv
`timescale 1ns/1ps
module oe_out_gate #(
  parameter int NUM_OUT = 4
) (
  input  logic               pd_n,
  input  logic [NUM_OUT-1:0] reg_oe,
  input  logic [NUM_OUT-1:0] save,
  input  logic [NUM_OUT-1:0] pen,
  output logic [NUM_OUT-1:0] run
);

  generate
    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
      always_comb begin
        if (!pd_n)           run[i] = 1'b0;
        else if (!reg_oe[i]) run[i] = 1'b0;
        else if (!save[i])   run[i] = 1'b0;
        else                 run[i] = pen[i];
      end
    end
  endgenerate

endmodule

// File: rtl/oe_pin_ctrl.sv
`timescale 1ns/1ps
module oe_pin_ctrl
  import oe_pin_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] pin_lvl,
  input  logic [1:0] pin1_role,
  input  logic [1:0] pin2_role,
  input  logic [1:0] pin3_role,
  input  logic [3:0] reg_oe,
  input  logic       lf_en,
  input  logic       tmr_rst_req,
  output logic [3:0] out_run,
  output logic       pwrdn_active,
  output logic [1:0] fsel,
  output logic       rst_pin_drive_en,
  output logic       rst_pin_level,
  output logic       lf_run
);

  logic               rst_int_n;
  logic [NUM_PINS-1:0] pin_s;
  pin_terms_t         terms;
  logic [NUM_OUT-1:0] gate_run;

  logic [NUM_OUT-1:0] run_d;
  logic               pd_d;
  logic [1:0]         fsel_d;
  logic               den_d;
  logic               lvl_d;
  logic               lf_d;

  oe_sync #(.WIDTH(1), .STAGES(RST_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_int_n)
  );

  oe_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     (pin_lvl),
    .q     (pin_s)
  );

  oe_role_decode u_decode (
    .pin_s   (pin_s),
    .role1   (pin1_role_e'(pin1_role)),
    .role2   (pin2_role_e'(pin2_role)),
    .role3   (pin3_role_e'(pin3_role)),
    .rst_req (tmr_rst_req),
    .terms   (terms)
  );

  oe_out_gate #(.NUM_OUT(NUM_OUT)) u_gate (
    .pd_n   (terms.pd_n),
    .reg_oe (reg_oe),
    .save   (terms.save),
    .pen    (terms.pen),
    .run    (gate_run)
  );

  always_comb begin
    run_d  = gate_run;
    pd_d   = ~terms.pd_n;
    fsel_d = terms.fsel;
    den_d  = terms.rst_oe;
    lvl_d  = terms.rst_lvl;
    lf_d   = lf_en;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      out_run          <= '0;
      pwrdn_active     <= 1'b0;
      fsel             <= 2'b00;
      rst_pin_drive_en <= 1'b0;
      rst_pin_level    <= 1'b1;
      lf_run           <= 1'b0;
    end else begin
      out_run          <= run_d;
      pwrdn_active     <= pd_d;
      fsel             <= fsel_d;
      rst_pin_drive_en <= den_d;
      rst_pin_level    <= lvl_d;
      lf_run           <= lf_d;
    end
  end

  // R2
  pd_stops_all_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    pwrdn_active |-> (out_run == '0));

  // R2
  lf_follows_en_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    lf_en |=> lf_run);

  generate
    for (genvar i = 0; i < NUM_OUT; i++) begin : g_oe_chk
      // R1
      reg_oe_stop_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
        !reg_oe[i] |=> !out_run[i]);
    end
  endgenerate

  // R7
  rstout_drive_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pin2_role == 2'd3) |=> rst_pin_drive_en);

  // R7
  rstout_level_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pin2_role == 2'd3 && tmr_rst_req) |=> !rst_pin_level);

  // R7
  rstout_idle_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pin2_role != 2'd3) |=> (!rst_pin_drive_en && rst_pin_level));

  // R6
  fsel0_unassigned_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pin1_role != 2'd3) |=> !fsel[0]);

  // R6
  fsel1_unassigned_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pin3_role != 2'd2) |=> !fsel[1]);

endmodule

// File: tb/oe_pin_ctrl_test.sv
`timescale 1ns/1ps
module oe_pin_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] pin_lvl;
  logic [1:0] pin1_role, pin2_role, pin3_role;
  logic [3:0] reg_oe;
  logic       lf_en, tmr_rst_req;
  logic [3:0] out_run;
  logic       pwrdn_active;
  logic [1:0] fsel;
  logic       rst_pin_drive_en, rst_pin_level, lf_run;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  oe_pin_ctrl uut (
    .clk              (clk),
    .rst_n            (rst_n),
    .pin_lvl          (pin_lvl),
    .pin1_role        (pin1_role),
    .pin2_role        (pin2_role),
    .pin3_role        (pin3_role),
    .reg_oe           (reg_oe),
    .lf_en            (lf_en),
    .tmr_rst_req      (tmr_rst_req),
    .out_run          (out_run),
    .pwrdn_active     (pwrdn_active),
    .fsel             (fsel),
    .rst_pin_drive_en (rst_pin_drive_en),
    .rst_pin_level    (rst_pin_level),
    .lf_run           (lf_run)
  );

  // stimulus: r1 r2 r3 pins(p3 p2 p1) oe(diff se3 se2 se1) lf rq
  // expect  : run(diff se3 se2 se1) pd fsel(b1 b0) den lvl lf
  localparam int NV = 16;
  localparam logic [24:0] VEC [NV] = '{
    {2'd0,2'd0,2'd0,3'b111,4'b1111,1'b1,1'b0, 4'b1111,1'b0,2'b00,1'b0,1'b1,1'b1},
    {2'd0,2'd0,2'd0,3'b110,4'b1111,1'b1,1'b0, 4'b1110,1'b0,2'b00,1'b0,1'b1,1'b1},
    {2'd0,2'd0,2'd0,3'b001,4'b1111,1'b0,1'b0, 4'b1001,1'b0,2'b00,1'b0,1'b1,1'b0},
    {2'd1,2'd0,2'd0,3'b110,4'b1111,1'b1,1'b0, 4'b0000,1'b1,2'b00,1'b0,1'b1,1'b1},
    {2'd1,2'd0,2'd0,3'b111,4'b0101,1'b1,1'b0, 4'b0101,1'b0,2'b00,1'b0,1'b1,1'b1},
    {2'd2,2'd2,2'd1,3'b111,4'b1111,1'b1,1'b0, 4'b1111,1'b0,2'b00,1'b0,1'b1,1'b1},
    {2'd2,2'd2,2'd1,3'b010,4'b1111,1'b1,1'b0, 4'b1010,1'b0,2'b00,1'b0,1'b1,1'b1},
    {2'd2,2'd2,2'd1,3'b111,4'b0110,1'b1,1'b0, 4'b0110,1'b0,2'b00,1'b0,1'b1,1'b1},
    {2'd0,2'd1,2'd0,3'b101,4'b1111,1'b1,1'b0, 4'b0111,1'b0,2'b00,1'b0,1'b1,1'b1},
    {2'd3,2'd0,2'd2,3'b100,4'b1111,1'b1,1'b0, 4'b1101,1'b0,2'b10,1'b0,1'b1,1'b1},
    {2'd3,2'd0,2'd2,3'b011,4'b1111,1'b1,1'b0, 4'b1111,1'b0,2'b01,1'b0,1'b1,1'b1},
    {2'd3,2'd0,2'd3,3'b111,4'b1111,1'b1,1'b0, 4'b1111,1'b0,2'b01,1'b0,1'b1,1'b1},
    {2'd0,2'd3,2'd0,3'b101,4'b1111,1'b1,1'b0, 4'b1111,1'b0,2'b00,1'b1,1'b1,1'b1},
    {2'd0,2'd3,2'd0,3'b101,4'b1111,1'b1,1'b1, 4'b1111,1'b0,2'b00,1'b1,1'b0,1'b1},
    {2'd0,2'd2,2'd0,3'b111,4'b0000,1'b1,1'b1, 4'b0000,1'b0,2'b00,1'b0,1'b1,1'b1},
    {2'd1,2'd1,2'd1,3'b110,4'b1111,1'b0,1'b0, 4'b0000,1'b1,2'b00,1'b0,1'b1,1'b0}
  };

  string vtag [NV] = '{"R4","R4","R4","R2","R1","R3","R3","R1",
                       "R4","R6","R6","R5","R7","R7","R7","R2"};

  function automatic logic [9:0] observed();
    return {out_run, pwrdn_active, fsel, rst_pin_drive_en, rst_pin_level, lf_run};
  endfunction

  task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b (run pd fsel den lvl lf)", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [14:0] s);
    {pin1_role, pin2_role, pin3_role, pin_lvl, reg_oe, lf_en, tmr_rst_req} = s;
  endtask

  initial begin
    rst_n = 1'b0;
    apply({2'd0,2'd0,2'd0,3'b111,4'b1111,1'b1,1'b0});
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", observed(), 10'b0000_0_00_0_1_0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R9", observed(), 10'b1111_0_00_0_1_1);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][24:10]);
      repeat (3) @(negedge clk);
      check(vtag[i], observed(), VEC[i][9:0]);
    end

    // R8: pin latency, exactly three edges
    apply({2'd0,2'd0,2'd0,3'b111,4'b1111,1'b1,1'b0});
    repeat (4) @(negedge clk);
    pin_lvl = 3'b110;
    @(negedge clk);
    check("R8", {6'd0, out_run}, {6'd0, 4'b1111});
    @(negedge clk);
    check("R8", {6'd0, out_run}, {6'd0, 4'b1111});
    @(negedge clk);
    check("R8", {6'd0, out_run}, {6'd0, 4'b1110});

    // R8 / R1: register enable takes effect at the first edge
    pin_lvl = 3'b111;
    repeat (4) @(negedge clk);
    reg_oe = 4'b0111;
    @(negedge clk);
    check("R1", {6'd0, out_run}, {6'd0, 4'b0111});

    // R7: pin 2 level ignored in reset-out role, both levels
    pin2_role = 2'd3;
    reg_oe    = 4'b1111;
    pin_lvl   = 3'b111;
    repeat (4) @(negedge clk);
    check("R7", observed(), 10'b1111_0_00_1_1_1);
    pin_lvl = 3'b101;
    repeat (4) @(negedge clk);
    check("R7", observed(), 10'b1111_0_00_1_1_1);
    tmr_rst_req = 1'b1;
    @(negedge clk);
    check("R7", observed(), 10'b1111_0_00_1_0_1);

    // R9: asynchronous reset mid-run
    #1 rst_n = 1'b0;
    #1 check("R9", observed(), 10'b0000_0_00_0_1_0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule